// File: doc/BRIEF.md
# System Clock Control Unit

This block chooses the system clock of a small microcontroller and decides which of its two oscillators may run. Both oscillators are modelled as tick enables inside one reference clock domain. The high-speed ticks feed a free-running 6-bit prescaler. The selected system clock leaves the block as a stream of single-cycle enable pulses, `sysclk_en`. That stream is either the high-speed ticks divided by a power of two or the low-speed ticks passed through.

Software reaches two byte-wide registers through a one-bit address, a write strobe and a combinational read port.

- **Configuration register (address 0).** It holds the clock selection and, for each oscillator, a keep-running bit. The keep-running bits decide whether the oscillator stays on while the CPU is halted.
- **Oscillator register (address 1).** It holds the enable of the high-speed internal oscillator and a read-only flag. The flag reports when that oscillator has counted out its stabilization time after being enabled.

Top module: `sysclk_ctrl`

## Requirements
- R1: The address-0 field in bits 7:5 selects the source. A value k from 0 to 6 gives one `sysclk_en` pulse per 2^k high-speed ticks. The value 7 makes `sysclk_en` follow the low-speed ticks.
- R2: Address 0 reads back {select[7:5], 000, hs_keep[1], ls_keep[0]}. Address 1 reads back {000000, stable[1], hs_enable[0]}. Unused bits always read 0, whatever was written.
- R3: After reset, address 0 reads 0x00 and address 1 reads 0x01.
- R4: The stable flag reads 0 when the enable goes from 0 to 1. It reads 1 once STABLE_TICKS high-speed ticks have been counted while the oscillator runs. Writes to bit 1 of address 1 have no effect.
- R5: Writing 0 to the enable clears the flag and the tick count at the same edge. This holds even in the cycle where the count would complete, and a later re-enable counts from zero.
- R6: `hs_osc_en` is 1 exactly when the enable bit is 1 and either the CPU is not halted or hs_keep is 1.
- R7: `ls_osc_en` follows ls_keep while halted. When not halted it is 1 if ls_keep is 1 or if the requested or the active selection is 7.
- R8: A written selection becomes active only at the high-speed tick that wraps the prescaler from 63 to 0. If the high-speed oscillator is stopped, it becomes active at once. A write in the wrap cycle itself waits for the next wrap. No period shorter than the old or new one is produced.
- R9: While `cpu_halted` is 1, `sysclk_en` is 0.
- R10: `sysclk_en` is a single-cycle pulse that only occurs in a cycle carrying a tick of the active source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_tick | input | 1 | High-speed oscillator tick enable |
| ls_tick | input | 1 | Low-speed oscillator tick enable |
| cpu_halted | input | 1 | CPU is in the halted state |
| bus_addr | input | 1 | Register select: 0 configuration, 1 oscillator |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register, unused bits 0 |
| sysclk_en | output | 1 | System clock enable pulse |
| hs_osc_en | output | 1 | High-speed oscillator run enable |
| ls_osc_en | output | 1 | Low-speed oscillator run enable |

## Verification
Two events can fall in the same cycle.

- **Selection write and prescaler wrap.** The bench first waits on a /64 pulse to locate the wrap. It then drives the write of a new selection in exactly the wrap cycle, and expects a further full 64-tick period before the new rate appears. A write placed one cycle later takes effect at the very next wrap.
- **Enable clear and end of stabilization.** The bench writes 0 to the enable in the cycle whose edge would raise the stable flag. The flag must stay 0, and the following re-enable must again take the full count.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    localparam int SEL_W   = 3;
    localparam int PRESC_W = (2 ** SEL_W) - 2;
    localparam int RSV0_W  = 8 - SEL_W - 2;
    localparam logic [SEL_W-1:0] SEL_LS = '1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             hs_keep;
        logic             ls_keep;
        logic             hs_en;
    } cfg_t;

endpackage

// File: rtl/sysclk_regs.sv
module sysclk_regs
    import sysclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       stab_flag,
    output cfg_t       cfg_q,
    output logic       en_next,
    output logic [7:0] bus_rdata
);

    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr) begin
            if (!bus_addr) begin
                cfg_d.sel     = bus_wdata[7 -: SEL_W];
                cfg_d.hs_keep = bus_wdata[1];
                cfg_d.ls_keep = bus_wdata[0];
            end else begin
                cfg_d.hs_en   = bus_wdata[0];
            end
        end
        en_next = cfg_d.hs_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{sel: '0, hs_keep: 1'b0, ls_keep: 1'b0, hs_en: 1'b1};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        if (!bus_addr) begin
            bus_rdata = {cfg_q.sel, {RSV0_W{1'b0}}, cfg_q.hs_keep, cfg_q.ls_keep};
        end else begin
            bus_rdata = {6'b000000, stab_flag, cfg_q.hs_en};
        end
    end

endmodule

// File: rtl/sysclk_stab.sv
module sysclk_stab #(
    parameter int STABLE_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_next,
    input  logic hs_run,
    output logic stab_flag
);

    localparam int CNT_W = (STABLE_TICKS > 1) ? $clog2(STABLE_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } stab_st_t;

    stab_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_next) begin
            st_d = '0;
        end else if (hs_run && !st_q.flag) begin
            if (st_q.cnt == LAST) begin
                st_d.flag = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stab_flag = st_q.flag;

endmodule

// File: rtl/sysclk_div.sv
module sysclk_div
    import sysclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_run,
    input  logic             hs_active,
    input  logic             ls_run,
    input  logic [SEL_W-1:0] sel_req,
    output logic             pulse_raw,
    output logic             wrap,
    output logic [SEL_W-1:0] act_code
);

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [SEL_W-1:0]   act;
    } div_st_t;

    div_st_t            st_d, st_q;
    logic [PRESC_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PRESC_W; i++) begin
            mask[i] = (i < int'(st_q.act));
        end
    end

    always_comb begin
        st_d  = st_q;
        wrap  = hs_run && (&st_q.presc);
        if (hs_run) begin
            st_d.presc = st_q.presc + 1'b1;
        end
        if (wrap || !hs_active) begin
            st_d.act = sel_req;
        end
        if (st_q.act == SEL_LS) begin
            pulse_raw = ls_run;
        end else begin
            pulse_raw = hs_run && (&(st_q.presc | ~mask));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_code = st_q.act;

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl #(
    parameter int STABLE_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_tick,
    input  logic       ls_tick,
    input  logic       cpu_halted,
    input  logic       bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       sysclk_en,
    output logic       hs_osc_en,
    output logic       ls_osc_en
);

    import sysclk_pkg::*;

    cfg_t             cfg;
    logic             en_next;
    logic             stab_flag;
    logic             hs_en_bit;
    logic             hs_keep;
    logic             hs_run;
    logic             ls_run;
    logic             pulse_raw;
    logic             div_wrap;
    logic [SEL_W-1:0] act_code;

    sysclk_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .stab_flag (stab_flag),
        .cfg_q     (cfg),
        .en_next   (en_next),
        .bus_rdata (bus_rdata)
    );

    assign hs_en_bit = cfg.hs_en;
    assign hs_keep   = cfg.hs_keep;

    always_comb begin
        hs_osc_en = hs_en_bit && (!cpu_halted || hs_keep);
        if (cpu_halted) begin
            ls_osc_en = cfg.ls_keep;
        end else begin
            ls_osc_en = cfg.ls_keep || (cfg.sel == SEL_LS) || (act_code == SEL_LS);
        end
        hs_run    = hs_tick && hs_osc_en;
        ls_run    = ls_tick && ls_osc_en;
        sysclk_en = pulse_raw && !cpu_halted;
    end

    sysclk_stab #(
        .STABLE_TICKS (STABLE_TICKS)
    ) u_stab (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_next   (en_next),
        .hs_run    (hs_run),
        .stab_flag (stab_flag)
    );

    sysclk_div u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_run    (hs_run),
        .hs_active (hs_osc_en),
        .ls_run    (ls_run),
        .sel_req   (cfg.sel),
        .pulse_raw (pulse_raw),
        .wrap      (div_wrap),
        .act_code  (act_code)
    );

endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_tick,
    input logic       ls_tick,
    input logic       cpu_halted,
    input logic       bus_addr,
    input logic [7:0] bus_rdata,
    input logic       sysclk_en,
    input logic       hs_osc_en,
    input logic       ls_osc_en,
    input logic       hs_en_bit,
    input logic       hs_keep,
    input logic       stab_flag,
    input logic       div_wrap,
    input logic [2:0] act_code
);

    a_r9_halt_blocks_clock: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halted |-> !sysclk_en);

    a_r10_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sysclk_en |-> (hs_tick || ls_tick));

    a_r8_switch_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_code) |-> $past(div_wrap || !hs_osc_en));

    a_r5_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        stab_flag |-> hs_en_bit);

    a_r6_halt_stops_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halted && !hs_keep) |-> !hs_osc_en);

    a_r7_ls_selected_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_halted && act_code == 3'b111) |-> ls_osc_en);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr ? (bus_rdata[7:2] == 6'd0) : (bus_rdata[4:2] == 3'd0)));

endmodule

bind sysclk_ctrl sysclk_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_tick    (hs_tick),
    .ls_tick    (ls_tick),
    .cpu_halted (cpu_halted),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .sysclk_en  (sysclk_en),
    .hs_osc_en  (hs_osc_en),
    .ls_osc_en  (ls_osc_en),
    .hs_en_bit  (hs_en_bit),
    .hs_keep    (hs_keep),
    .stab_flag  (stab_flag),
    .div_wrap   (div_wrap),
    .act_code   (act_code)
);

// File: tb/sysclk_ctrl_tb.sv
module sysclk_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_tick = 1'b1;
    logic       ls_tick = 1'b0;
    logic       cpu_halted = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sysclk_en;
    logic       hs_osc_en;
    logic       ls_osc_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sysclk_ctrl #(.STABLE_TICKS(16)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_tick    (hs_tick),
        .ls_tick    (ls_tick),
        .cpu_halted (cpu_halted),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .sysclk_en  (sysclk_en),
        .hs_osc_en  (hs_osc_en),
        .ls_osc_en  (ls_osc_en)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        cyc();
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(1'b0, d); chk(d, 8'h00, "R3 config reset");
        rd(1'b1, d); chk(d, 8'h01, "R3 oscillator reset");
        chk(hs_osc_en, 1'b1, "R6 hs runs after reset");
        chk(ls_osc_en, 1'b0, "R7 ls idle after reset");
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        wr(1'b0, 8'hFF);
        rd(1'b0, d); chk(d, 8'hE3, "R2 config unused bits");
        wr(1'b0, 8'h00);
        rd(1'b0, d); chk(d, 8'h00, "R2 config cleared");
    endtask

    task automatic t_div(input int k);
        int n = 0;
        wr(1'b0, 8'(k << 5));
        idle(70);
        for (int i = 0; i < 128; i++) begin
            cyc(); #1;
            if (sysclk_en) n++;
        end
        chk(n, 128 >> k, $sformatf("R1 pulses per 128 ticks code %0d", k));
    endtask

    task automatic t_sparse();
        int n = 0;
        int bad = 0;
        wr(1'b0, 8'h20);
        idle(70);
        for (int i = 0; i < 256; i++) begin
            cyc();
            hs_tick = i[0];
            #1;
            if (sysclk_en) n++;
            if (sysclk_en && !hs_tick) bad++;
        end
        hs_tick = 1'b1;
        chk(n, 64, "R1 code 1 with ticks every other cycle");
        chk(bad, 0, "R10 no pulse without tick");
    endtask

    task automatic t_ls();
        int bad = 0;
        wr(1'b0, 8'hE0);
        idle(70);
        chk(ls_osc_en, 1'b1, "R7 ls runs when selected");
        for (int i = 0; i < 30; i++) begin
            cyc();
            ls_tick = (i % 3 == 0);
            #1;
            if (sysclk_en !== ls_tick) bad++;
        end
        ls_tick = 1'b0;
        chk(bad, 0, "R1 code 7 follows ls ticks");
    endtask

    task automatic find_pulse();
        for (int i = 0; i < 200; i++) begin
            cyc(); #1;
            if (sysclk_en) break;
        end
    endtask

    task automatic t_switch_late();
        int bad = 0;
        t_div(6);
        find_pulse();
        for (int i = 1; i <= 65; i++) begin
            cyc();
            bus_addr = 1'b0; bus_wdata = 8'h00; bus_wr = (i == 1);
            #1;
            if (sysclk_en !== (i >= 64)) bad++;
        end
        bus_wr = 1'b0;
        chk(bad, 0, "R8 write after wrap applies at next wrap");
    endtask

    task automatic t_switch_same();
        int bad = 0;
        t_div(6);
        find_pulse();
        for (int i = 1; i <= 129; i++) begin
            cyc();
            bus_addr = 1'b0; bus_wdata = 8'h00; bus_wr = (i == 64);
            #1;
            if (sysclk_en !== ((i == 64) || (i >= 128))) bad++;
        end
        bus_wr = 1'b0;
        chk(bad, 0, "R8 write in wrap cycle waits a full period");
    endtask

    task automatic t_halt();
        int n = 0;
        wr(1'b0, 8'h02);
        cyc();
        cpu_halted = 1'b1; ls_tick = 1'b1;
        for (int i = 0; i < 20; i++) begin
            cyc(); #1;
            if (sysclk_en) n++;
        end
        chk(n, 0, "R9 no clock while halted");
        chk(hs_osc_en, 1'b1, "R6 hs kept in halt");
        chk(ls_osc_en, 1'b0, "R7 ls stopped in halt");
        wr(1'b0, 8'h01);
        #1;
        chk(hs_osc_en, 1'b0, "R6 hs stopped in halt");
        chk(ls_osc_en, 1'b1, "R7 ls kept in halt");
        chk(sysclk_en, 1'b0, "R9 still gated");
        cyc();
        cpu_halted = 1'b0; ls_tick = 1'b0;
        wr(1'b0, 8'h00);
        #1;
        chk(hs_osc_en, 1'b1, "R6 hs runs after halt");
    endtask

    task automatic t_stab();
        logic [7:0] d;
        wr(1'b1, 8'h00);
        rd(1'b1, d); chk(d, 8'h00, "R5 disable clears flag");
        chk(hs_osc_en, 1'b0, "R6 hs off when disabled");
        wr(1'b1, 8'hFE);
        rd(1'b1, d); chk(d, 8'h00, "R4 flag not writable");
        wr(1'b1, 8'h01);
        rd(1'b1, d); chk(d, 8'h01, "R4 flag low after enable");
        idle(15);
        rd(1'b1, d); chk(d, 8'h01, "R4 flag low one tick early");
        idle(1);
        rd(1'b1, d); chk(d, 8'h03, "R4 flag high after count");
    endtask

    task automatic t_stab_race();
        logic [7:0] d;
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h01);
        idle(14);
        cyc();
        bus_addr = 1'b1; bus_wdata = 8'h00; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
        rd(1'b1, d); chk(d, 8'h00, "R5 clear wins over completion");
        wr(1'b1, 8'h01);
        idle(15);
        rd(1'b1, d); chk(d, 8'h01, "R5 count restarted");
        idle(1);
        rd(1'b1, d); chk(d, 8'h03, "R5 full count after restart");
    endtask

    initial begin
        #600000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        t_reset();
        t_reserved();
        for (int k = 0; k < 7; k++) t_div(k);
        t_sparse();
        t_ls();
        t_switch_late();
        t_switch_same();
        t_halt();
        t_stab();
        t_stab_race();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule